// File: doc/BRIEF.md
# Four-Channel Timer Capture Unit

This block watches four capture pins and, when a chosen edge appears on one of them, copies the value of a free-running counter into that channel's capture register. It then sets the channel's status flag. Each channel has its own two-bit edge selector, a flag, and an interrupt enable. The enabled flags are combined into a single interrupt request. The counter itself sits outside the block and arrives on an input port.

The last channel shares its capture register and pin with a fifth output-compare function. A mode bit chooses between the two roles, and the block comes out of reset in the compare role. In the compare role the register can be written, and a match against the counter sets the channel's flag. In the capture role, writes to the register are dropped.

The shared pin has a direction bit and an output data bit. When the pin is set as an output and capture is enabled, a write to the data bit produces an edge that is captured in the same way as an external edge. Software reaches all state through a small word-wide register port: writes are synchronous and reads are combinational.

Top module: `tic_capture_unit`

## Requirements
- R1: After reset the following are all zero: the edge-select word (address 0), the control word (address 1), the flags (address 2), the interrupt enables (address 3), `irq_o` and `shr_pin_oe`.
- R2: Edge-select code 01 captures on rising edges only. The field for channel n is at bits 2n+1:2n of address 0.
- R3: Edge-select code 10 captures on falling edges only.
- R4: Edge-select code 11 captures on both rising and falling edges.
- R5: Edge-select code 00 disables the channel, so pin edges set no flag.
- R6: A pin change made between two clock edges sets the flag after the third rising clock edge that follows it, and not earlier. The capture register at address 4+n holds the counter value that was present during the clock cycle just before that edge.
- R7: Channels that see their edges in the same cycle all latch the same counter value.
- R8: A capture sets the channel's flag (address 2, bit n). Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some flag bit and its enable bit (address 3, bit n) are both 1.
- R10: With the mode bit (address 1, bit 0) at 0, channel 3 does not capture, and address 7 can be written and read back. When the counter equals that value, flag bit 3 is set.
- R11: With the mode bit at 1, writes to address 7 are ignored, and channel 3 captures like the other channels.
- R12: Address 1 bit 1 sets the shared pin as an output (`shr_pin_oe`), and bit 2 is the value it drives (`shr_pin_o`). While the pin is an output, `cap_pin_i[3]` is ignored and changes to bit 2 are captured. Such a change is captured with one cycle more latency than a pin change, because of the extra write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| cnt_i | input | CNT_W | Free-running counter value |
| cap_pin_i | input | NCH | Asynchronous capture pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| shr_pin_o | output | 1 | Shared pin drive value |
| shr_pin_oe | output | 1 | Shared pin output enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that a capture pin stays stable long enough for the two-flop chain to resolve. They also assume that a load strobe from an edge detector implies a live edge select for that channel, and that the counter input is a plain binary value. The bench only toggles pins at falling clock edges, and keeps each level for several cycles, so every edge passes the chain cleanly. It switches the shared pin's source only at points where the resulting transition is of a polarity the channel ignores, or where the test expects a capture.

// File: rtl/tic_pkg.sv
package tic_pkg;

    parameter int NCH = 4;

    typedef enum logic [2:0] {
        A_EDGE = 3'd0,
        A_CTRL = 3'd1,
        A_FLAG = 3'd2,
        A_IEN  = 3'd3,
        A_CAP0 = 3'd4,
        A_CAP1 = 3'd5,
        A_CAP2 = 3'd6,
        A_CAP3 = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

endpackage

// File: rtl/tic_edge_det.sv
module tic_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] sel_i,
    output logic       hit_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } st_t;

    st_t  st_d, st_q;
    logic lvl, rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        lvl       = st_q.sync[SYNC_STAGES-1];
        rise      = lvl & ~st_q.prev;
        fall      = ~lvl & st_q.prev;
        hit_o     = (rise & sel_i[0]) | (fall & sel_i[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tic_oc_match.sv
module tic_oc_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic         en_i,
    output logic         match_o
);
    always_comb match_o = en_i && (cnt_i == cmp_i);
endmodule

// File: rtl/tic_capture_unit.sv
module tic_capture_unit
    import tic_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [NCH-1:0]    cap_pin_i,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              shr_pin_o,
    output logic              shr_pin_oe,
    output logic              irq_o
);
    localparam int SEL_W = 2 * NCH;
    localparam int LAST  = NCH - 1;

    typedef struct packed {
        logic [SEL_W-1:0]          esel;
        logic                      shr_cap;
        logic                      shr_dir;
        logic                      shr_dat;
        logic [NCH-1:0]            flag;
        logic [NCH-1:0]            ien;
        logic [NCH-1:0][CNT_W-1:0] cap;
    } st_t;

    st_t            st_d, st_q;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] set_flag;
    logic [NCH-1:0] clr_flag;
    logic           oc_match;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic       src;
        logic [1:0] sel;
        if (ch == LAST) begin : g_shared
            assign src = st_q.shr_dir ? st_q.shr_dat : cap_pin_i[ch];
            assign sel = st_q.esel[2*ch +: 2] & {2{st_q.shr_cap}};
        end else begin : g_plain
            assign src = cap_pin_i[ch];
            assign sel = st_q.esel[2*ch +: 2];
        end
        tic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (src),
            .sel_i (sel),
            .hit_o (hit[ch])
        );
    end

    tic_oc_match #(.W(CNT_W)) u_oc (
        .cnt_i   (cnt_i),
        .cmp_i   (st_q.cap[LAST]),
        .en_i    (!st_q.shr_cap),
        .match_o (oc_match)
    );

    always_comb begin
        st_d           = st_q;
        clr_flag       = '0;
        set_flag       = hit;
        set_flag[LAST] = st_q.shr_cap ? hit[LAST] : oc_match;

        if (bus_we) begin
            case (bus_addr)
                A_EDGE: st_d.esel = bus_wdata[SEL_W-1:0];
                A_CTRL: {st_d.shr_dat, st_d.shr_dir, st_d.shr_cap} = bus_wdata[2:0];
                A_FLAG: clr_flag  = bus_wdata[NCH-1:0];
                A_IEN:  st_d.ien  = bus_wdata[NCH-1:0];
                A_CAP3: if (!st_q.shr_cap) st_d.cap[LAST] = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end

        for (int i = 0; i < NCH; i++) begin
            if (hit[i]) st_d.cap[i] = cnt_i;
        end

        st_d.flag = (st_q.flag & ~clr_flag) | set_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cap <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_EDGE:  bus_rdata[SEL_W-1:0] = st_q.esel;
            A_CTRL:  bus_rdata[2:0]       = {st_q.shr_dat, st_q.shr_dir, st_q.shr_cap};
            A_FLAG:  bus_rdata[NCH-1:0]   = st_q.flag;
            A_IEN:   bus_rdata[NCH-1:0]   = st_q.ien;
            default: bus_rdata[CNT_W-1:0] = st_q.cap[bus_addr[1:0]];
        endcase
    end

    assign shr_pin_o  = st_q.shr_dat;
    assign shr_pin_oe = st_q.shr_dir;
    assign irq_o      = |(st_q.flag & st_q.ien);
endmodule

// File: rtl/tic_capture_chk.sv
module tic_capture_chk
    import tic_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CNT_W-1:0]          cnt_i,
    input logic [NCH-1:0]            hit,
    input logic [NCH-1:0]            flag,
    input logic [NCH-1:0]            ien,
    input logic [2*NCH-1:0]          esel,
    input logic [NCH-1:0][CNT_W-1:0] cap,
    input logic                      shr_cap,
    input logic                      bus_we,
    input logic [2:0]                bus_addr,
    input logic                      irq_o
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> cap[i] == $past(cnt_i));
        assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag[i]);
        assert_off_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (esel[2*i +: 2] == 2'b00) |-> !hit[i]);
        if (i < NCH - 1) begin : g_hold
            assert_cap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !hit[i] |=> $stable(cap[i]));
        end
    end

    assert_shared_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_cap && !hit[NCH-1]) |=> $stable(cap[NCH-1]));
    assert_compare_no_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !shr_cap |-> !hit[NCH-1]);
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & ien) == '0) |-> !irq_o);
    assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & ien) != '0) |-> irq_o);
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_FLAG && hit == '0 && !(!shr_cap && flag[NCH-1]))
            |=> (flag & ~$past(flag)) == '0 || !shr_cap);
endmodule

bind tic_capture_unit tic_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_i    (cnt_i),
    .hit      (hit),
    .flag     (st_q.flag),
    .ien      (st_q.ien),
    .esel     (st_q.esel),
    .cap      (st_q.cap),
    .shr_cap  (st_q.shr_cap),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq_o    (irq_o)
);

// File: tb/tic_capture_unit_tb.sv
module tic_capture_unit_tb;
    import tic_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = '0;
    logic [3:0]  pins = '0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        po, poe, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          ch;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 16'd1;

    tic_capture_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_i      (cnt),
        .cap_pin_i  (pins),
        .bus_we     (we),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .shr_pin_o  (po),
        .shr_pin_oe (poe),
        .irq_o      (irq)
    );

    task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic push(int ch, logic [15:0] v, string tag);
        exp_t e;
        e.ch = ch; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic drive(int ch, logic v, bit expect_cap, string tag);
        @(negedge clk);
        pins[ch] = v;
        if (expect_cap) push(ch, cnt + 16'd2, tag);
    endtask

    task automatic monitor_drain();
        logic [15:0] f, c;
        exp_t e;
        repeat (5) @(negedge clk);
        rd(A_FLAG, f);
        while (sbq.size() > 0) begin
            e = sbq.pop_front();
            chk_eq({e.tag, " flag"}, 32'(f[e.ch]), 32'd1);
            rd(3'(4 + e.ch), c);
            chk_eq({e.tag, " captured value"}, 32'(c), 32'(e.val));
        end
        wr(A_FLAG, 16'h000F);
    endtask

    task automatic expect_none(int ch, string tag);
        logic [15:0] f;
        repeat (5) @(negedge clk);
        rd(A_FLAG, f);
        chk_eq({tag, " no capture"}, 32'(f[ch]), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] d, c3, cs;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_EDGE, d); chk_eq("R1 edge select", 32'(d), 32'd0);
        rd(A_CTRL, d); chk_eq("R1 control", 32'(d), 32'd0);
        rd(A_FLAG, d); chk_eq("R1 flags", 32'(d), 32'd0);
        rd(A_IEN, d);  chk_eq("R1 enables", 32'(d), 32'd0);
        chk_eq("R1 irq", 32'(irq), 32'd0);
        chk_eq("R1 pin oe", 32'(poe), 32'd0);

        // ch0 rise, ch1 fall, ch2 any, ch3 rise
        wr(A_EDGE, 16'h0079);
        drive(0, 1'b1, 1, "R2 rising");   monitor_drain();
        drive(0, 1'b0, 0, "");            expect_none(0, "R2 falling ignored");
        drive(1, 1'b1, 0, "");            expect_none(1, "R3 rising ignored");
        drive(1, 1'b0, 1, "R3 falling");  monitor_drain();
        drive(2, 1'b1, 1, "R4 rising");   monitor_drain();
        drive(2, 1'b0, 1, "R4 falling");  monitor_drain();

        // R5 disabled channel
        wr(A_EDGE, 16'h0078);
        drive(0, 1'b1, 0, "");            expect_none(0, "R5 disabled");

        // R7 simultaneous edges on three channels
        wr(A_EDGE, 16'h007F);
        @(negedge clk);
        pins[0] = 1'b0; pins[1] = 1'b1; pins[2] = 1'b1;
        push(0, cnt + 16'd2, "R7 ch0");
        push(1, cnt + 16'd2, "R7 ch1");
        push(2, cnt + 16'd2, "R7 ch2");
        monitor_drain();

        // R6 latency of the flag
        addr = A_FLAG;
        drive(2, 1'b0, 1, "R6 value");
        @(negedge clk);
        @(negedge clk); #1;
        chk_eq("R6 flag not before third edge", 32'(rdata[2]), 32'd0);
        @(negedge clk); #1;
        chk_eq("R6 flag after third edge", 32'(rdata[2]), 32'd1);
        monitor_drain();

        // R8 / R9 flag clearing and interrupt
        drive(0, 1'b1, 0, "");
        repeat (5) @(negedge clk);
        rd(A_FLAG, d); chk_eq("R8 flag set", 32'(d[0]), 32'd1);
        wr(A_FLAG, 16'h0000);
        rd(A_FLAG, d); chk_eq("R8 write 0 keeps flag", 32'(d[0]), 32'd1);
        wr(A_FLAG, 16'h0002);
        rd(A_FLAG, d); chk_eq("R8 other bit keeps flag", 32'(d[0]), 32'd1);
        chk_eq("R9 irq masked", 32'(irq), 32'd0);
        wr(A_IEN, 16'h0001);
        #1; chk_eq("R9 irq raised", 32'(irq), 32'd1);
        wr(A_FLAG, 16'h0001);
        rd(A_FLAG, d); chk_eq("R8 write 1 clears", 32'(d[0]), 32'd0);
        chk_eq("R9 irq dropped", 32'(irq), 32'd0);
        wr(A_IEN, 16'h0000);

        // R10 compare role of the shared channel
        drive(3, 1'b1, 0, "");            expect_none(3, "R10 compare role");
        @(negedge clk);
        c3 = cnt + 16'd20;
        we = 1'b1; addr = A_CAP3; wdata = c3;
        @(negedge clk);
        we = 1'b0;
        rd(A_CAP3, d); chk_eq("R10 register write", 32'(d), 32'(c3));
        repeat (25) @(negedge clk);
        rd(A_FLAG, d); chk_eq("R10 compare flag", 32'(d[3]), 32'd1);
        wr(A_FLAG, 16'h000F);

        // R11 capture role of the shared channel
        wr(A_CTRL, 16'h0001);
        wr(A_CAP3, 16'h1234);
        rd(A_CAP3, d); chk_eq("R11 write ignored", 32'(d), 32'(c3));
        drive(3, 1'b0, 0, "");
        drive(3, 1'b1, 1, "R11 capture");
        monitor_drain();
        rd(A_CAP3, cs);
        wr(A_CAP3, 16'h4321);
        rd(A_CAP3, d); chk_eq("R11 write after capture ignored", 32'(d), 32'(cs));

        // R12 shared pin as output
        wr(A_CTRL, 16'h0003);
        #1;
        chk_eq("R12 oe", 32'(poe), 32'd1);
        chk_eq("R12 drive low", 32'(po), 32'd0);
        expect_none(3, "R12 source switch");
        drive(3, 1'b0, 0, "");
        drive(3, 1'b1, 0, "");
        expect_none(3, "R12 input ignored");
        @(negedge clk);
        push(3, cnt + 16'd3, "R12 pin write");
        we = 1'b1; addr = A_CTRL; wdata = 16'h0007;
        @(negedge clk);
        we = 1'b0;
        #1;
        chk_eq("R12 drive high", 32'(po), 32'd1);
        monitor_drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule